// File: doc/BRIEF.md
# DMA Channel Control and Status

This block holds the control and status state for a single DMA channel and decides when a transfer has finished. Software reaches it over a small register bus. It can pick the address mode (dual or single), enable the end-of-transfer interrupt, enable the channel, load a transfer count and watch a done flag. The datapath that runs the bus cycles sends one `xfer_done` pulse for each completed unit. While the channel is active, each pulse takes one off the count. When the count reaches zero, the done flag is set and the channel goes idle.

A non-maskable-interrupt abort or an address-error abort stops the channel. So does clearing the global master enable or the channel enable. None of these sets the done flag, and the remaining count stays readable. Clearing the done flag takes two bus operations: a read that returns the flag as 1, then a write of 0. While the flag is set the channel cannot run, whatever is written to the enable bit.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The mode bit (CTRL bit 1) resets to 0, meaning dual-address transfers. `addr_mode` always equals the mode bit, and 1 means single-address transfers.
- R2: `irq_req` is a level output that is 1 exactly when the interrupt-enable bit (CTRL bit 2) and the done flag (CTRL bit 7) are both 1.
- R3: A `xfer_done` pulse while the channel is active and the count is 1 sets the count to 0 and the done flag to 1 at the same clock edge. Nothing else sets the flag.
- R4: An abort, a master-enable drop or an enable clear while the count is nonzero leaves the done flag at 0 and the count unchanged.
- R5: A write of 0 to the done bit clears the flag only when the previous CTRL access was a read that returned the flag as 1. Any write to CTRL uses up that permission, whatever value it writes.
- R6: Software writes of 1 to the done bit have no effect.
- R7: While the done flag is 1, `chan_act` stays 0, even after a write of 1 to the enable bit (CTRL bit 0).
- R8: `chan_act` is 1 exactly when the enable bit is 1, `master_en` is 1, the done flag is 0, and neither `nmi_abort` nor `addr_err` is asserted.
- R9: `nmi_abort` or `addr_err` clears the enable bit at the next edge. This overrides a write to the bit in the same cycle.
- R10: A write to COUNT (address 1) loads it. A `xfer_done` pulse decrements it only when `chan_act` is 1 and the count is nonzero, and a COUNT write in the same cycle takes priority.
- R11: While `standby` is 1, the enable, mode, interrupt-enable and done bits and the clear permission are reset to 0. The count is kept, and bus writes and pulses are ignored. Hardware reset also zeroes the count.
- R12: `bus_rdata` is combinational. CTRL (address 0) returns the bits enable 0, mode 1, interrupt-enable 2 and done 7, with all other bits 0. COUNT returns the count zero-extended. Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous low-power reset of control bits |
| master_en | input | 1 | Global DMA master enable |
| nmi_abort | input | 1 | Non-maskable interrupt abort |
| addr_err | input | 1 | Address-error abort |
| xfer_done | input | 1 | One completed transfer unit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| chan_act | output | 1 | Channel may run transfers |
| addr_mode | output | 1 | 0 dual-address, 1 single-address |
| irq_req | output | 1 | End-of-transfer interrupt request |

## Verification
The assertions check these on every cycle:
- The done flag only rises when the count is zero.
- An abort cycle never raises the flag and always drops the enable.
- The flag only falls after a clear permission or a standby.
- An idle count holds its value.
- Standby wipes the control bits.

Only the bench scenarios can show the following. The read-then-write clear sequence must be in the right order, and a stray write must use up the permission. A re-enable attempt with the flag set must be refused. The count must survive aborts and standby. The bench compares its model with every output on every cycle, including a long stretch of mixed stimulus.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned MODE_BIT = 1;
    localparam int unsigned IE_BIT   = 2;
    localparam int unsigned DONE_BIT = 7;

    localparam int unsigned CTRL_OFS = 0;
    localparam int unsigned CNT_OFS  = 1;

    typedef enum logic {
        MODE_DUAL   = 1'b0,
        MODE_SINGLE = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic       en;
        xfer_mode_e mode;
        logic       ie;
        logic       done;
        logic       arm;
    } ctrl_st_t;
endpackage

// File: rtl/dmc_bus_dec.sv
module dmc_bus_dec
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              standby,
    input  ctrl_st_t          st_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic              wr_ctrl,
    output logic              wr_cnt,
    output logic              rd_ctrl,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFS);

    logic hit_ctrl;
    logic hit_cnt;

    always_comb begin
        hit_ctrl = (bus_addr == CTRL_A);
        hit_cnt  = (bus_addr == CNT_A);
        wr_ctrl  = bus_wr & hit_ctrl & ~standby;
        wr_cnt   = bus_wr & hit_cnt & ~standby;
        rd_ctrl  = bus_rd & ~bus_wr & hit_ctrl & ~standby;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[EN_BIT]   = st_q.en;
            bus_rdata[MODE_BIT] = st_q.mode;
            bus_rdata[IE_BIT]   = st_q.ie;
            bus_rdata[DONE_BIT] = st_q.done;
        end else if (hit_cnt) begin
            bus_rdata = DATA_W'(cnt_q);
        end
    end
endmodule

// File: rtl/dmc_xfer_cnt.sv
module dmc_xfer_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata_cnt,
    input  logic             dec_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;
    logic             dec_ok;

    always_comb begin
        dec_ok   = dec_req & ~standby & ~wr_cnt & (cnt_q != '0);
        zero_evt = dec_ok & (cnt_q == ONE);
        cnt_d    = cnt_q;
        if (!standby) begin
            if (wr_cnt)      cnt_d = wdata_cnt;
            else if (dec_ok) cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !dec_req) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/dmc_ctrl_regs.sv
module dmc_ctrl_regs
    import dmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     standby,
    input  logic     abort,
    input  logic     wr_ctrl,
    input  logic     rd_ctrl,
    input  logic     w_en,
    input  logic     w_mode,
    input  logic     w_ie,
    input  logic     w_done,
    input  logic     zero_evt,
    output ctrl_st_t st_q
);
    ctrl_st_t st_d;

    always_comb begin
        st_d = st_q;
        if (standby) begin
            st_d = '0;
        end else begin
            if (wr_ctrl) begin
                st_d.en   = w_en;
                st_d.mode = xfer_mode_e'(w_mode);
                st_d.ie   = w_ie;
                if (st_q.arm && !w_done) st_d.done = 1'b0;
                st_d.arm  = 1'b0;
            end else if (rd_ctrl && st_q.done) begin
                st_d.arm = 1'b1;
            end
            if (abort)    st_d.en   = 1'b0;
            if (zero_evt) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ABORT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !st_q.en); // R9
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.done) |-> ($past(st_q.arm) || $past(standby))); // R5
    AST_STANDBY_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!st_q.done && !st_q.ie && st_q.mode == MODE_DUAL && !st_q.en)); // R11
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              master_en,
    input  logic              nmi_abort,
    input  logic              addr_err,
    input  logic              xfer_done,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              chan_act,
    output logic              addr_mode,
    output logic              irq_req
);
    ctrl_st_t         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl;
    logic             wr_cnt;
    logic             rd_ctrl;
    logic             zero_evt;
    logic             abort;

    assign abort     = nmi_abort | addr_err;
    assign chan_act  = st_q.en & master_en & ~st_q.done & ~abort;
    assign addr_mode = st_q.mode;
    assign irq_req   = st_q.ie & st_q.done;

    dmc_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .standby   (standby),
        .st_q      (st_q),
        .cnt_q     (cnt_q),
        .wr_ctrl   (wr_ctrl),
        .wr_cnt    (wr_cnt),
        .rd_ctrl   (rd_ctrl),
        .bus_rdata (bus_rdata)
    );

    dmc_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .wr_cnt    (wr_cnt),
        .wdata_cnt (bus_wdata[CNT_W-1:0]),
        .dec_req   (xfer_done & chan_act),
        .cnt_q     (cnt_q),
        .zero_evt  (zero_evt)
    );

    dmc_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .abort    (abort),
        .wr_ctrl  (wr_ctrl),
        .rd_ctrl  (rd_ctrl),
        .w_en     (bus_wdata[EN_BIT]),
        .w_mode   (bus_wdata[MODE_BIT]),
        .w_ie     (bus_wdata[IE_BIT]),
        .w_done   (bus_wdata[DONE_BIT]),
        .zero_evt (zero_evt),
        .st_q     (st_q)
    );

    AST_DONE_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> (cnt_q == '0)); // R3
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !st_q.done) |=> !st_q.done); // R4
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b0, master_en = 1'b0, nmi_abort = 1'b0, addr_err = 1'b0;
    logic xfer_done = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic chan_act, addr_mode, irq_req;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // reference state
    bit m_en, m_mode, m_ie, m_done, m_arm;
    int m_cnt;

    always #2.5 clk = ~clk;

    dma_chan_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .master_en(master_en),
        .nmi_abort(nmi_abort), .addr_err(addr_err), .xfer_done(xfer_done),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chan_act(chan_act), .addr_mode(addr_mode), .irq_req(irq_req)
    );

    function automatic bit m_act();
        return m_en && master_en && !m_done && !nmi_abort && !addr_err;
    endfunction

    function automatic int m_rdata();
        if (bus_addr == 0) return (int'(m_en)) | (int'(m_mode) << 1) | (int'(m_ie) << 2) | (int'(m_done) << 7);
        if (bus_addr == 1) return m_cnt;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit act, wctrl, wcnt, rctrl, dec, zero;
        act   = m_act();
        wctrl = bus_wr && bus_addr == 0;
        wcnt  = bus_wr && bus_addr == 1;
        rctrl = bus_rd && !bus_wr && bus_addr == 0;
        if (standby) begin
            m_en = 0; m_mode = 0; m_ie = 0; m_done = 0; m_arm = 0;
            return;
        end
        dec  = xfer_done && act && m_cnt != 0 && !wcnt;
        zero = dec && m_cnt == 1;
        if (wcnt) m_cnt = int'(bus_wdata[CNT_W-1:0]);
        else if (dec) m_cnt = m_cnt - 1;
        if (wctrl) begin
            m_en = bus_wdata[0]; m_mode = bus_wdata[1]; m_ie = bus_wdata[2];
            if (m_arm && !bus_wdata[7]) m_done = 0;
            m_arm = 0;
        end else if (rctrl && m_done) m_arm = 1;
        if (nmi_abort || addr_err) m_en = 0;
        if (zero) m_done = 1;
    endtask

    // compare every output against the model, then advance one clock
    task automatic step();
        #1;
        chk(int'(bus_rdata) == m_rdata(), "R12 rdata", int'(bus_rdata), m_rdata());
        chk(chan_act == m_act(), "R8 chan_act", int'(chan_act), int'(m_act()));
        chk(irq_req == (m_ie && m_done), "R2 irq_req", int'(irq_req), int'(m_ie && m_done));
        chk(addr_mode == m_mode, "R1 addr_mode", int'(addr_mode), int'(m_mode));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        bus_wr = 0; bus_rd = 0; xfer_done = 0; nmi_abort = 0; addr_err = 0; standby = 0;
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); step(); quiet();
    endtask

    task automatic rd(input int a, output int d);
        bus_rd = 1; bus_addr = ADDR_W'(a); #1 d = int'(bus_rdata); step(); quiet();
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin xfer_done = 1; step(); quiet(); end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_en = 0; m_mode = 0; m_ie = 0; m_done = 0; m_arm = 0; m_cnt = 0;
        // reset state
        rd(0, d); chk(d == 0, "R11 reset ctrl", d, 0);
        rd(1, d); chk(d == 0, "R11 reset count", d, 0);
        // R1 mode select and R2 enable
        wr(0, 32'h6); chk(addr_mode == 1, "R1 single mode", int'(addr_mode), 1);
        master_en = 1;
        wr(1, 3); wr(0, 32'h7);
        #1 chk(chan_act == 1, "R8 active", int'(chan_act), 1);
        pulse(2); rd(0, d); chk(d == 32'h7, "R3 no done before zero", d, 32'h7);
        pulse(1); rd(1, d); chk(d == 0, "R3 count zero", d, 0);
        #1 chk(irq_req == 1, "R2 irq on done", int'(irq_req), 1);
        chk(chan_act == 0, "R7 idle when done", int'(chan_act), 0);
        // R5 write 0 without fresh read armed? the earlier rd(1) did not arm; rd(0) earlier was before done
        wr(0, 32'h7); rd(1, d);
        rd(0, d); chk(d[7] == 1, "R5 no clear without read", int'(d[7]), 1);
        // R7 re-enable refused
        #1 chk(chan_act == 0, "R7 re-enable refused", int'(chan_act), 0);
        // arm then write with done bit 1: consumed, no clear
        wr(0, 32'h87); rd(1, d);
        rd(0, d); chk(d[7] == 1, "R6 write 1 keeps done", int'(d[7]), 1);
        wr(0, 32'h6);  // consumed previous arm from rd(0): clears now
        rd(0, d); chk(d[7] == 0, "R5 read-then-write clears", int'(d[7]), 0);
        wr(0, 32'h80); rd(0, d); chk(d[7] == 0, "R6 software set ignored", int'(d[7]), 0);
        // R4 / R9 aborts keep count and done
        wr(1, 5); wr(0, 32'h1); pulse(2);
        nmi_abort = 1; xfer_done = 1; step(); quiet();
        rd(0, d); chk(d == 0, "R9 nmi clears enable", d, 0);
        rd(1, d); chk(d == 3, "R4 count retained", d, 3);
        wr(0, 32'h1); addr_err = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1; step(); quiet();
        rd(0, d); chk(d == 0, "R9 abort beats write", d, 0);
        wr(0, 32'h1); master_en = 0; pulse(3);
        rd(1, d); chk(d == 3, "R10 no count when master off", d, 3);
        master_en = 1; wr(0, 0); pulse(2);
        rd(0, d); chk(d == 0, "R4 enable cleared no done", d, 0);
        // R10 zero count ignored
        wr(1, 0); wr(0, 32'h1); pulse(2);
        rd(0, d); chk(d == 1, "R10 zero count no done", d, 1);
        // R11 standby
        wr(1, 9); wr(0, 32'h7); standby = 1; step(); quiet();
        rd(0, d); chk(d == 0, "R11 standby clears ctrl", d, 0);
        rd(1, d); chk(d == 9, "R11 standby keeps count", d, 9);
        // R12 unmapped address
        wr(5, -1); rd(5, d); chk(d == 0, "R12 unmapped reads 0", d, 0);
        rd(0, d); chk(d == 0, "R12 unmapped write ignored", d, 0);
        // mixed stimulus phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            bus_wr    = (r < 25);
            bus_rd    = (r >= 20 && r < 50);
            bus_addr  = ADDR_W'($urandom % 3);
            bus_wdata = (bus_addr == 1) ? DATA_W'($urandom % 6) : DATA_W'($urandom);
            xfer_done = ($urandom % 2) == 1;
            nmi_abort = ($urandom % 40) == 0;
            addr_err  = ($urandom % 40) == 0;
            standby   = ($urandom % 150) == 0;
            master_en = ($urandom % 10) != 0;
            step();
        end
        quiet();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule